// File: doc/BRIEF.md
# Temperature-Driven Fan PWM Controller

This block converts a periodically refreshed die-temperature reading into a slow pulse-width-modulated drive for a cooling fan. Its duty cycle follows a programmable profile. Below a start temperature the fan is off. Once that temperature is reached, the fan starts at once at a minimum duty. Above that point the duty climbs linearly with temperature until it saturates at full drive. Changes in the applied duty are rate-limited so that the acoustic noise of the fan drifts slowly instead of stepping.

The same temperature reading drives two protection flags, each with a one-degree release band. The first asks the system to throttle its clock. The second, set at a higher critical temperature, requests shutdown. The critical threshold comes from two strap pins unless software supplies its own, so shutdown protection works with an unconfigured block. Temperatures are unsigned whole degrees and duty values are integer percent.

Top module: `fan_pwm_ctrl`

## Requirements
- R1: While the latched temperature is below cfg_start_i, the applied duty drops to 0 in the next cycle and the fan output stays low.
- R2: When the applied duty is 0 and the target becomes non-zero, the applied duty jumps in one cycle to cfg_min_i (clamped to 100, and at least 1), without rate limiting.
- R3: At or above cfg_start_i, the target duty is min(100, clamp(cfg_min_i) + cfg_slope_i × (temperature − cfg_start_i)) and never wraps, whatever the slope.
- R4: A PWM frame is 100 slots of SLOT_CYC clocks each. pwm_o is high during the first D slots of a frame, where D is the applied duty latched at the start of that frame, so a duty change takes effect only at a frame boundary.
- R5: While the fan is running, the applied duty moves toward the target by at most cfg_slew_i percent once every SEC_CYC clocks, both upward and downward.
- R6: throttle_o sets when the temperature is at or above cfg_throttle_i. It clears only once the temperature falls below cfg_throttle_i − 1.
- R7: shutdown_o follows the same set and release rule against the critical threshold. That threshold is cfg_crit_i when cfg_crit_ovr_i is 1. Otherwise it is CRIT_BASE + CRIT_STEP × strap_i (100, 105, 110 or 115 by default).
- R8: After reset, the applied duty is 0, pwm_o is low and both flags are clear until the first valid temperature sample arrives.
- R9: temp_i is captured only in a cycle where temp_vld_i is 1. At any other time, temp_i has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_i | input | TEMP_W | Die temperature, unsigned degrees |
| temp_vld_i | input | 1 | Strobe: temp_i holds a new sample |
| cfg_start_i | input | TEMP_W | Fan start temperature |
| cfg_min_i | input | 7 | Starting duty in percent |
| cfg_slope_i | input | SLOPE_W | Duty increase in percent per degree |
| cfg_slew_i | input | 7 | Largest duty step per rate period |
| cfg_throttle_i | input | TEMP_W | Clock-throttle threshold |
| cfg_crit_ovr_i | input | 1 | Use cfg_crit_i instead of the strap-selected value |
| cfg_crit_i | input | TEMP_W | Software critical threshold |
| strap_i | input | 2 | Selects the default critical threshold |
| pwm_o | output | 1 | Fan drive |
| throttle_o | output | 1 | Clock-throttle request |
| shutdown_o | output | 1 | Shutdown request |

## Verification
Random profiles with full-speed slewing compare the measured high time per frame against the profile formula. These cases separate a wrong offset, slope or saturation from correct operation, including samples below the start point and steep slopes that would overflow. A slewing step test with a small rate limit shows apart a limited ramp and an instant jump, in both directions. A frozen rate limit isolates the jump to the minimum duty at start-up. Threshold walks one degree at a time show whether the set point and the release band are placed correctly, for both the strap-selected and the software critical threshold.

// File: rtl/fan_pkg.sv
package fan_pkg;
  localparam int PCT_W = 7;
  typedef logic [PCT_W-1:0] pct_t;
  localparam pct_t PCT_FULL = pct_t'(100);

  function automatic pct_t pct_clamp(input pct_t v);
    return (v > PCT_FULL) ? PCT_FULL : v;
  endfunction
endpackage

// File: rtl/fan_curve.sv
module fan_curve
  import fan_pkg::*;
#(
  parameter int TEMP_W  = 8,
  parameter int SLOPE_W = 8
) (
  input  logic [TEMP_W-1:0]  temp_i,
  input  logic [TEMP_W-1:0]  start_i,
  input  pct_t               min_i,
  input  logic [SLOPE_W-1:0] slope_i,
  output pct_t               target_o
);
  localparam int RAMP_W = TEMP_W + SLOPE_W + 1;

  logic [TEMP_W-1:0] diff;
  logic [RAMP_W-1:0] ramp;

  always_comb begin
    diff = temp_i - start_i;
    ramp = RAMP_W'(pct_clamp(min_i)) + RAMP_W'(slope_i) * RAMP_W'(diff);
    if (temp_i < start_i)
      target_o = '0;
    else if (ramp > RAMP_W'(PCT_FULL))
      target_o = PCT_FULL;
    else
      target_o = ramp[PCT_W-1:0];
  end
endmodule

// File: rtl/fan_slew.sv
module fan_slew
  import fan_pkg::*;
#(
  parameter int unsigned SEC_CYC = 200_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic have_i,
  input  pct_t target_i,
  input  pct_t min_i,
  input  pct_t step_i,
  output pct_t applied_o
);
  localparam int CNT_W = (SEC_CYC > 1) ? $clog2(SEC_CYC) : 1;

  logic [CNT_W-1:0] tick_q, tick_d;
  logic             tick;
  pct_t             app_q, app_d, start_pct, gap;

  always_comb begin
    tick      = (tick_q == CNT_W'(SEC_CYC - 1));
    tick_d    = tick ? '0 : tick_q + 1'b1;
    start_pct = (pct_clamp(min_i) == '0) ? pct_t'(1) : pct_clamp(min_i);
    gap       = (app_q > target_i) ? (app_q - target_i) : (target_i - app_q);
    app_d     = app_q;
    if (!have_i || target_i == '0)
      app_d = '0;
    else if (app_q == '0)
      app_d = start_pct;
    else if (tick) begin
      if (app_q < target_i)
        app_d = app_q + ((gap < step_i) ? gap : step_i);
      else if (app_q > target_i)
        app_d = app_q - ((gap < step_i) ? gap : step_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      app_q  <= '0;
    end else begin
      tick_q <= tick_d;
      app_q  <= app_d;
    end
  end

  assign applied_o = app_q;
endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen
  import fan_pkg::*;
#(
  parameter int unsigned SLOT_CYC = 66_667
) (
  input  logic clk,
  input  logic rst_n,
  input  pct_t duty_i,
  output logic pwm_o,
  output logic frame_start_o,
  output pct_t frame_duty_o
);
  localparam int SLOT_W = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;

  logic [SLOT_W-1:0] slot_q, slot_d;
  pct_t              pos_q, pos_d, duty_q, duty_d;
  logic              slot_end;

  always_comb begin
    slot_end      = (slot_q == SLOT_W'(SLOT_CYC - 1));
    frame_start_o = slot_end && (pos_q == PCT_FULL - 1'b1);
    slot_d        = slot_end ? '0 : slot_q + 1'b1;
    pos_d         = pos_q;
    if (slot_end)
      pos_d = frame_start_o ? '0 : pos_q + 1'b1;
    duty_d = frame_start_o ? pct_clamp(duty_i) : duty_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      pos_q  <= '0;
      duty_q <= '0;
    end else begin
      slot_q <= slot_d;
      pos_q  <= pos_d;
      duty_q <= duty_d;
    end
  end

  assign pwm_o        = (pos_q < duty_q);
  assign frame_duty_o = duty_q;
endmodule

// File: rtl/fan_trip.sv
module fan_trip #(
  parameter int TEMP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              have_i,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic [TEMP_W-1:0] thr_i,
  output logic              flag_o
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (!have_i)
      flag_d = 1'b0;
    else if (temp_i >= thr_i)
      flag_d = 1'b1;
    else if (({1'b0, temp_i} + 1'b1) < {1'b0, thr_i})
      flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/fan_pwm_ctrl.sv
module fan_pwm_ctrl
  import fan_pkg::*;
#(
  parameter int          TEMP_W    = 8,
  parameter int          SLOPE_W   = 8,
  parameter int unsigned SLOT_CYC  = 66_667,
  parameter int unsigned SEC_CYC   = 200_000_000,
  parameter int          CRIT_BASE = 100,
  parameter int          CRIT_STEP = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TEMP_W-1:0]  temp_i,
  input  logic               temp_vld_i,
  input  logic [TEMP_W-1:0]  cfg_start_i,
  input  logic [6:0]         cfg_min_i,
  input  logic [SLOPE_W-1:0] cfg_slope_i,
  input  logic [6:0]         cfg_slew_i,
  input  logic [TEMP_W-1:0]  cfg_throttle_i,
  input  logic               cfg_crit_ovr_i,
  input  logic [TEMP_W-1:0]  cfg_crit_i,
  input  logic [1:0]         strap_i,
  output logic               pwm_o,
  output logic               throttle_o,
  output logic               shutdown_o
);
  localparam int NFLAG = 2;

  logic [TEMP_W-1:0] temp_q, temp_d, crit_thr;
  logic              have_q, have_d;
  pct_t              target, applied, frame_duty;
  logic              frame_start;
  logic [TEMP_W-1:0] thr [NFLAG];
  logic [NFLAG-1:0]  flags;

  always_comb begin
    temp_d = temp_vld_i ? temp_i : temp_q;
    have_d = have_q | temp_vld_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      temp_q <= '0;
      have_q <= 1'b0;
    end else begin
      temp_q <= temp_d;
      have_q <= have_d;
    end
  end

  fan_curve #(.TEMP_W(TEMP_W), .SLOPE_W(SLOPE_W)) u_curve (
    .temp_i(temp_q), .start_i(cfg_start_i), .min_i(cfg_min_i),
    .slope_i(cfg_slope_i), .target_o(target)
  );

  fan_slew #(.SEC_CYC(SEC_CYC)) u_slew (
    .clk(clk), .rst_n(rst_n), .have_i(have_q), .target_i(target),
    .min_i(cfg_min_i), .step_i(cfg_slew_i), .applied_o(applied)
  );

  fan_pwm_gen #(.SLOT_CYC(SLOT_CYC)) u_pwm (
    .clk(clk), .rst_n(rst_n), .duty_i(applied), .pwm_o(pwm_o),
    .frame_start_o(frame_start), .frame_duty_o(frame_duty)
  );

  assign crit_thr = cfg_crit_ovr_i ? cfg_crit_i
                  : TEMP_W'(CRIT_BASE) + TEMP_W'(CRIT_STEP) * TEMP_W'(strap_i);
  assign thr[0]   = cfg_throttle_i;
  assign thr[1]   = crit_thr;

  for (genvar gi = 0; gi < NFLAG; gi++) begin : g_trip
    fan_trip #(.TEMP_W(TEMP_W)) u_trip (
      .clk(clk), .rst_n(rst_n), .have_i(have_q), .temp_i(temp_q),
      .thr_i(thr[gi]), .flag_o(flags[gi])
    );
  end

  assign throttle_o = flags[0];
  assign shutdown_o = flags[1];
endmodule

// File: rtl/fan_pwm_ctrl_chk.sv
module fan_pwm_ctrl_chk #(
  parameter int TEMP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              have,
  input logic [TEMP_W-1:0] temp_q,
  input logic [TEMP_W-1:0] thr_throt,
  input logic [6:0]        applied,
  input logic [6:0]        step,
  input logic              frame_start,
  input logic [6:0]        frame_duty,
  input logic              throttle,
  input logic              shutdown
);
  // R5
  slew_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(applied) != 0 && applied != 0) |->
      (((applied > $past(applied)) ? (applied - $past(applied))
                                   : ($past(applied) - applied)) <= $past(step)));
  // R4
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(frame_duty));
  // R3
  duty_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    applied <= 7'd100);
  // R6
  throttle_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (have && temp_q >= thr_throt && $stable(thr_throt)) |=> throttle);
  // R8
  idle_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !have |-> (!throttle && !shutdown && applied == 0));
endmodule

bind fan_pwm_ctrl fan_pwm_ctrl_chk #(.TEMP_W(TEMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .have(have_q), .temp_q(temp_q),
  .thr_throt(cfg_throttle_i), .applied(applied), .step(cfg_slew_i),
  .frame_start(frame_start), .frame_duty(frame_duty),
  .throttle(throttle_o), .shutdown(shutdown_o)
);

// File: tb/tb_fan_pwm_ctrl.sv
`timescale 1ns/1ps
module tb_fan_pwm_ctrl;
  localparam int SLOT = 4;
  localparam int SEC  = 200;
  localparam int FRAME = 100 * SLOT;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] temp_i, cfg_start, cfg_throt, cfg_crit;
  logic       temp_vld, cfg_crit_ovr;
  logic [6:0] cfg_min, cfg_slew;
  logic [7:0] cfg_slope;
  logic [1:0] strap;
  logic       pwm, throttle, shutdown;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  fan_pwm_ctrl #(.SLOT_CYC(SLOT), .SEC_CYC(SEC)) dut (
    .clk(clk), .rst_n(rst_n), .temp_i(temp_i), .temp_vld_i(temp_vld),
    .cfg_start_i(cfg_start), .cfg_min_i(cfg_min), .cfg_slope_i(cfg_slope),
    .cfg_slew_i(cfg_slew), .cfg_throttle_i(cfg_throt),
    .cfg_crit_ovr_i(cfg_crit_ovr), .cfg_crit_i(cfg_crit), .strap_i(strap),
    .pwm_o(pwm), .throttle_o(throttle), .shutdown_o(shutdown)
  );

  function automatic int exp_duty(int t, int s, int m, int k);
    int mc, v;
    if (t < s) return 0;
    mc = (m > 100) ? 100 : m;
    v  = mc + k * (t - s);
    return (v > 100) ? 100 : v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic send(input int t);
    @(posedge clk); #1;
    temp_i = 8'(t); temp_vld = 1'b1;
    @(posedge clk); #1;
    temp_vld = 1'b0;
  endtask

  task automatic measure(output int hi);
    hi = 0;
    for (int i = 0; i < FRAME; i++) begin
      @(negedge clk);
      if (pwm) hi++;
    end
  endtask

  task automatic settle_and_measure(output int hi);
    repeat (1200) @(posedge clk);
    measure(hi);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int hi, e;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; temp_i = 8'd200; temp_vld = 1'b0;
    cfg_start = 8'd50; cfg_min = 7'd40; cfg_slope = 8'd3; cfg_slew = 7'd100;
    cfg_throt = 8'd90; cfg_crit_ovr = 1'b0; cfg_crit = 8'd250; strap = 2'd2;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;

    // R8 / R9: no sample yet, hot value on temp_i without strobe
    measure(hi);
    check(hi == 0, "R8 pwm idle", hi, 0);
    check(!throttle && !shutdown, "R8 flags idle", {throttle, shutdown}, 0);
    repeat (1000) @(posedge clk);
    measure(hi);
    check(hi == 0 && !shutdown, "R9 no strobe no effect", hi, 0);

    // R1 below start
    send(45);
    settle_and_measure(hi);
    check(hi == 0, "R1 below start off", hi, 0);

    // R2 jump to minimum with slew frozen
    cfg_slew = 7'd0;
    send(60);
    settle_and_measure(hi);
    check(hi == 40 * SLOT, "R2 start at min", hi, 40 * SLOT);
    // R9 change temp_i without strobe
    temp_i = 8'd20;
    settle_and_measure(hi);
    check(hi == 40 * SLOT, "R9 unstrobed temp ignored", hi, 40 * SLOT);
    // R1 drop to off immediately even with frozen slew
    send(49);
    settle_and_measure(hi);
    check(hi == 0, "R1 off below start", hi, 0);

    // R3 / R4 random profiles, fast slew
    cfg_slew = 7'd100;
    for (int it = 0; it < 16; it++) begin
      int s, m, k, t;
      s = 20 + int'($urandom % 40);
      m = 1 + int'($urandom % 100);
      k = int'($urandom % 24);
      t = s - 5 + int'($urandom % 45);
      cfg_start = 8'(s); cfg_min = 7'(m); cfg_slope = 8'(k);
      send(t);
      settle_and_measure(hi);
      e = exp_duty(t, s, m, k);
      check(hi == e * SLOT, "R3 R4 profile duty", hi, e * SLOT);
    end
    // R3 steep slope clamps, no wrap
    cfg_start = 8'd30; cfg_min = 7'd50; cfg_slope = 8'd255;
    send(255);
    settle_and_measure(hi);
    check(hi == 100 * SLOT, "R3 clamp steep slope", hi, 100 * SLOT);
    cfg_min = 7'd120; cfg_slope = 8'd0;
    send(30);
    settle_and_measure(hi);
    check(hi == 100 * SLOT, "R3 min clamp", hi, 100 * SLOT);

    // R5 slew limit up and down
    cfg_start = 8'd50; cfg_min = 7'd40; cfg_slope = 8'd3; cfg_slew = 7'd100;
    send(50);
    settle_and_measure(hi);
    check(hi == 40 * SLOT, "R5 setup", hi, 40 * SLOT);
    cfg_slew = 7'd5;
    send(70);
    measure(hi);
    check(hi >= 40 * SLOT && hi <= 50 * SLOT, "R5 limited rise", hi, 45 * SLOT);
    repeat (6000) @(posedge clk);
    measure(hi);
    check(hi == 100 * SLOT, "R5 reaches target up", hi, 100 * SLOT);
    send(50);
    measure(hi);
    check(hi >= 90 * SLOT, "R5 limited fall", hi, 95 * SLOT);
    repeat (6000) @(posedge clk);
    measure(hi);
    check(hi == 40 * SLOT, "R5 reaches target down", hi, 40 * SLOT);

    // R6 throttle hysteresis (threshold 90)
    send(89); repeat (5) @(posedge clk);
    check(!throttle, "R6 below thr", throttle, 0);
    send(90); repeat (5) @(posedge clk);
    check(throttle, "R6 set at thr", throttle, 1);
    send(89); repeat (5) @(posedge clk);
    check(throttle, "R6 held in band", throttle, 1);
    send(88); repeat (5) @(posedge clk);
    check(!throttle, "R6 released", throttle, 0);

    // R7 strap 2 -> 110
    send(109); repeat (5) @(posedge clk);
    check(!shutdown, "R7 strap below", shutdown, 0);
    send(110); repeat (5) @(posedge clk);
    check(shutdown, "R7 strap set", shutdown, 1);
    send(109); repeat (5) @(posedge clk);
    check(shutdown, "R7 strap band", shutdown, 1);
    send(108); repeat (5) @(posedge clk);
    check(!shutdown, "R7 strap release", shutdown, 0);
    strap = 2'd0;
    send(100); repeat (5) @(posedge clk);
    check(shutdown, "R7 strap0 at 100", shutdown, 1);
    send(60); repeat (5) @(posedge clk);
    // R7 software override
    cfg_crit_ovr = 1'b1; cfg_crit = 8'd70;
    send(69); repeat (5) @(posedge clk);
    check(!shutdown, "R7 override below", shutdown, 0);
    send(70); repeat (5) @(posedge clk);
    check(shutdown, "R7 override set", shutdown, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule